// File: doc/BRIEF.md
# Paged Address Translator with Translation Cache

This block turns 32-bit virtual addresses into physical addresses using 512-byte pages. Each address is split into a 23-bit page number (bits 31:9) and a 9-bit byte offset (bits 8:0). The physical address is the frame number shifted left by nine bits, with the offset placed in the low nine bits unchanged. A fully associative translation cache of eight entries holds recent page-to-frame mappings. It is searched on every request. A hit answers in one cycle.

On a miss the block reads a page table entry from an internal table, which system software loads through a write port and inspects through a read port. Each entry holds a frame number, a valid flag, a dirty (modified) flag, an accessed (referenced) flag and a two-bit permission code. A lookup that finds a valid entry installs the mapping in the cache, choosing victim slots in rotating order. Each successful access sets the accessed flag, and a successful write also sets the dirty flag.

Software must pulse the flush input at every context switch. Because cached mappings are not tracked against later table writes, software must also flush after it changes a table entry.

Top module: `pgx_xlate`

## Requirements
- R1: A successful translation returns resp_paddr = {frame, vaddr[8:0]}, that is frame*512 + offset, with the page number taken from vaddr[31:9].
- R2: A page fault (resp_page_fault=1, resp_prot_fault=0, resp_paddr=0) is reported when the selected entry has valid=0, or when the page number is not below 2**PT_IDX_W. The table entry whose index matches the low page bits is left untouched.
- R3: Permission codes: 00 allows nothing, 01 allows read, 10 allows read and write, 11 allows read and execute. Access kinds: req_kind 00 read, 01 write, 10 execute, 11 never allowed. A disallowed access gives resp_prot_fault=1, resp_page_fault=0 and resp_paddr=0.
- R4: Every translation without a fault sets the accessed flag of its table entry, on both hit and miss. A faulting access leaves the flag unchanged.
- R5: A write translation without a fault sets the dirty flag of its entry. A read or execute translation leaves the dirty flag unchanged.
- R6: req_ready is 1 in the idle state. A request accepted on a cache hit gives resp_valid one cycle after the accepting edge. A miss holds req_ready low for two cycles and gives resp_valid three cycles after the accepting edge.
- R7: A miss that finds a valid entry in range installs the mapping, even when the access itself has a permission fault. Later accesses to that page hit and use the cached frame and permission, even if the table entry has been rewritten since.
- R8: The cache has TLB_DEPTH (8) slots, filled in rotating order from slot 0. The ninth distinct installed page evicts the first one.
- R9: A tlb_flush pulse empties the cache and resets the rotation to slot 0. A flush that arrives while a miss is in progress still lets that miss answer correctly, but its mapping is not installed.
- R10: pt_wr_en writes a full entry at pt_wr_idx. If this write lands in the same cycle as a flag update on the same entry, the write wins. The pt_rd_* outputs show the entry at pt_rd_idx combinationally.
- R11: After reset, req_ready=1, resp_valid=0, the cache is empty and every table entry is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_paddr | output | 32 | Physical address, zero on fault |
| resp_page_fault | output | 1 | Entry invalid or page out of range |
| resp_prot_fault | output | 1 | Access not permitted |
| tlb_flush | input | 1 | Invalidate all cached mappings |
| pt_wr_en | input | 1 | Table entry write strobe |
| pt_wr_idx | input | PT_IDX_W | Entry index to write |
| pt_wr_frame | input | 23 | Frame number to write |
| pt_wr_valid | input | 1 | Valid flag to write |
| pt_wr_mod | input | 1 | Dirty flag to write |
| pt_wr_ref | input | 1 | Accessed flag to write |
| pt_wr_prot | input | 2 | Permission code to write |
| pt_rd_idx | input | PT_IDX_W | Entry index to observe |
| pt_rd_frame | output | 23 | Observed frame number |
| pt_rd_valid | output | 1 | Observed valid flag |
| pt_rd_mod | output | 1 | Observed dirty flag |
| pt_rd_ref | output | 1 | Observed accessed flag |
| pt_rd_prot | output | 2 | Observed permission code |

## Verification
A response is due at a fixed number of cycles after the accepting edge: one for a hit and three for a miss. The bench counts falling edges from the acceptance until resp_valid rises and compares that count with the expected latency, so the count shows whether the cache hit or missed. It then compares the address and fault flags in that same sample. Flag updates in the table take effect at the response edge, so the bench reads them through the read port after the response has been seen. A flush during a miss is driven exactly in the walk cycle, and the bench then checks that the next access to that page costs three cycles again.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 9;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = 23;

  localparam logic [1:0] ACC_READ  = 2'b00;
  localparam logic [1:0] ACC_WRITE = 2'b01;
  localparam logic [1:0] ACC_EXEC  = 2'b10;

  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_RO   = 2'b01;
  localparam logic [1:0] PERM_RW   = 2'b10;
  localparam logic [1:0] PERM_RX   = 2'b11;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic             vld;
    logic             mod;
    logic             refd;
    logic [1:0]       prot;
  } pte_t;

  function automatic logic perm_allows(input logic [1:0] prot, input logic [1:0] kind);
    case (prot)
      PERM_RO: return kind == ACC_READ;
      PERM_RW: return (kind == ACC_READ) || (kind == ACC_WRITE);
      PERM_RX: return (kind == ACC_READ) || (kind == ACC_EXEC);
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pgx_ptab.sv
module pgx_ptab
  import pgx_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  pte_t             wr_pte,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx,
  input  logic             mark_wr,
  input  logic [IDX_W-1:0] a_idx,
  output logic [PFN_W-1:0] a_pfn,
  output logic             a_vld,
  output logic [1:0]       a_prot,
  input  logic [IDX_W-1:0] b_idx,
  output pte_t             b_pte
);
  localparam int ENTRIES = 1 << IDX_W;

  pte_t tab_q [ENTRIES];
  pte_t tab_n [ENTRIES];

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      tab_n[i] = tab_q[i];
      if (wr_en && (wr_idx == IDX_W'(i))) begin
        tab_n[i] = wr_pte;
      end else if (mark_en && (mark_idx == IDX_W'(i))) begin
        tab_n[i].refd = 1'b1;
        if (mark_wr) tab_n[i].mod = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tab_q[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) tab_q[i] <= tab_n[i];
    end
  end

  assign a_pfn  = tab_q[a_idx].pfn;
  assign a_vld  = tab_q[a_idx].vld;
  assign a_prot = tab_q[a_idx].prot;
  assign b_pte  = tab_q[b_idx];
endmodule

// File: rtl/pgx_tlb.sv
module pgx_tlb
  import pgx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic [1:0]       lk_prot,
  input  logic             flush,
  input  logic             ins_en,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PFN_W-1:0] ins_pfn,
  input  logic [1:0]       ins_prot,
  output logic [DEPTH-1:0] vld_vec
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DEPTH-1:0] vld_q, vld_n;
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic [VPN_W-1:0] tag_q  [DEPTH];
  logic [PFN_W-1:0] pfn_q  [DEPTH];
  logic [1:0]       prot_q [DEPTH];
  logic [DEPTH-1:0] match;
  logic             wr_slot;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match[g] = vld_q[g] && (tag_q[g] == lk_vpn);
    end
  endgenerate

  always_comb begin
    lk_hit  = |match;
    lk_pfn  = '0;
    lk_prot = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) begin
        lk_pfn  = lk_pfn | pfn_q[i];
        lk_prot = lk_prot | prot_q[i];
      end
    end
  end

  assign wr_slot = ins_en && !flush;

  always_comb begin
    vld_n = vld_q;
    ptr_n = ptr_q;
    if (flush) begin
      vld_n = '0;
      ptr_n = '0;
    end else if (ins_en) begin
      vld_n[ptr_q] = 1'b1;
      ptr_n = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_n;
      ptr_q <= ptr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_slot) begin
      tag_q[ptr_q]  <= ins_vpn;
      pfn_q[ptr_q]  <= ins_pfn;
      prot_q[ptr_q] <= ins_prot;
    end
  end

  assign vld_vec = vld_q;
endmodule

// File: rtl/pgx_ctrl.sv
module pgx_ctrl
  import pgx_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             flush,
  output logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_hit,
  input  logic [PFN_W-1:0] lk_pfn,
  input  logic [1:0]       lk_prot,
  output logic             ins_en,
  output logic [VPN_W-1:0] ins_vpn,
  output logic [PFN_W-1:0] ins_pfn,
  output logic [1:0]       ins_prot,
  output logic [IDX_W-1:0] walk_idx,
  input  logic [PFN_W-1:0] walk_pfn,
  input  logic             walk_vld,
  input  logic [1:0]       walk_prot,
  output logic             mark_en,
  output logic [IDX_W-1:0] mark_idx,
  output logic             mark_wr,
  output logic             resp_valid,
  output logic [VA_W-1:0]  resp_paddr,
  output logic             resp_pgf,
  output logic             resp_prf
);
  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_FILL} st_e;

  st_e              st_q, st_n;
  logic [VPN_W-1:0] vpn_q, vpn_n;
  logic [OFF_W-1:0] off_q, off_n;
  logic [1:0]       kind_q, kind_n;
  logic [PFN_W-1:0] epfn_q, epfn_n;
  logic             evld_q, evld_n;
  logic [1:0]       eprot_q, eprot_n;
  logic             kill_q, kill_n;
  logic             rv_n;
  logic [VA_W-1:0]  pa_n;
  logic             pgf_n, prf_n;
  logic             ok;
  logic             in_range;

  assign req_ready = (st_q == ST_IDLE);
  assign lk_vpn    = req_vaddr[VA_W-1:OFF_W];
  assign walk_idx  = vpn_q[IDX_W-1:0];
  assign in_range  = (vpn_q[VPN_W-1:IDX_W] == '0);
  assign ins_vpn   = vpn_q;
  assign ins_pfn   = epfn_q;
  assign ins_prot  = eprot_q;

  always_comb begin
    st_n     = st_q;
    vpn_n    = vpn_q;
    off_n    = off_q;
    kind_n   = kind_q;
    epfn_n   = epfn_q;
    evld_n   = evld_q;
    eprot_n  = eprot_q;
    kill_n   = kill_q;
    rv_n     = 1'b0;
    pa_n     = '0;
    pgf_n    = 1'b0;
    prf_n    = 1'b0;
    ok       = 1'b0;
    ins_en   = 1'b0;
    mark_en  = 1'b0;
    mark_idx = vpn_q[IDX_W-1:0];
    mark_wr  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        kill_n = 1'b0;
        if (req_valid) begin
          if (lk_hit) begin
            ok       = perm_allows(lk_prot, req_kind);
            rv_n     = 1'b1;
            pa_n     = ok ? {lk_pfn, req_vaddr[OFF_W-1:0]} : '0;
            prf_n    = !ok;
            mark_en  = ok;
            mark_idx = req_vaddr[OFF_W +: IDX_W];
            mark_wr  = ok && (req_kind == ACC_WRITE);
          end else begin
            st_n   = ST_WALK;
            vpn_n  = req_vaddr[VA_W-1:OFF_W];
            off_n  = req_vaddr[OFF_W-1:0];
            kind_n = req_kind;
          end
        end
      end
      ST_WALK: begin
        epfn_n  = walk_pfn;
        evld_n  = walk_vld;
        eprot_n = walk_prot;
        kill_n  = kill_q || flush;
        st_n    = ST_FILL;
      end
      ST_FILL: begin
        st_n = ST_IDLE;
        rv_n = 1'b1;
        if (!in_range || !evld_q) begin
          pgf_n = 1'b1;
        end else begin
          ins_en  = !(kill_q || flush);
          ok      = perm_allows(eprot_q, kind_q);
          pa_n    = ok ? {epfn_q, off_q} : '0;
          prf_n   = !ok;
          mark_en = ok;
          mark_wr = ok && (kind_q == ACC_WRITE);
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      kill_q     <= 1'b0;
      resp_valid <= 1'b0;
    end else begin
      st_q       <= st_n;
      kill_q     <= kill_n;
      resp_valid <= rv_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q   <= '0;
      off_q   <= '0;
      kind_q  <= '0;
      epfn_q  <= '0;
      evld_q  <= 1'b0;
      eprot_q <= '0;
    end else begin
      vpn_q   <= vpn_n;
      off_q   <= off_n;
      kind_q  <= kind_n;
      epfn_q  <= epfn_n;
      evld_q  <= evld_n;
      eprot_q <= eprot_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_paddr <= '0;
      resp_pgf   <= 1'b0;
      resp_prf   <= 1'b0;
    end else if (rv_n) begin
      resp_paddr <= pa_n;
      resp_pgf   <= pgf_n;
      resp_prf   <= prf_n;
    end
  end
endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate
  import pgx_pkg::*;
#(
  parameter int TLB_DEPTH = 8,
  parameter int PT_IDX_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [31:0]         req_vaddr,
  input  logic [1:0]          req_kind,
  output logic                resp_valid,
  output logic [31:0]         resp_paddr,
  output logic                resp_page_fault,
  output logic                resp_prot_fault,
  input  logic                tlb_flush,
  input  logic                pt_wr_en,
  input  logic [PT_IDX_W-1:0] pt_wr_idx,
  input  logic [22:0]         pt_wr_frame,
  input  logic                pt_wr_valid,
  input  logic                pt_wr_mod,
  input  logic                pt_wr_ref,
  input  logic [1:0]          pt_wr_prot,
  input  logic [PT_IDX_W-1:0] pt_rd_idx,
  output logic [22:0]         pt_rd_frame,
  output logic                pt_rd_valid,
  output logic                pt_rd_mod,
  output logic                pt_rd_ref,
  output logic [1:0]          pt_rd_prot
);
  logic [VPN_W-1:0]    lk_vpn;
  logic                lk_hit;
  logic [PFN_W-1:0]    lk_pfn;
  logic [1:0]          lk_prot;
  logic                ins_en;
  logic [VPN_W-1:0]    ins_vpn;
  logic [PFN_W-1:0]    ins_pfn;
  logic [1:0]          ins_prot;
  logic [PT_IDX_W-1:0] walk_idx;
  logic [PFN_W-1:0]    walk_pfn;
  logic                walk_vld;
  logic [1:0]          walk_prot;
  logic                mark_en;
  logic [PT_IDX_W-1:0] mark_idx;
  logic                mark_wr;
  logic [TLB_DEPTH-1:0] tlb_vld;
  pte_t                wr_pte;
  pte_t                rd_pte;

  always_comb begin
    wr_pte.pfn  = pt_wr_frame;
    wr_pte.vld  = pt_wr_valid;
    wr_pte.mod  = pt_wr_mod;
    wr_pte.refd = pt_wr_ref;
    wr_pte.prot = pt_wr_prot;
  end

  assign pt_rd_frame = rd_pte.pfn;
  assign pt_rd_valid = rd_pte.vld;
  assign pt_rd_mod   = rd_pte.mod;
  assign pt_rd_ref   = rd_pte.refd;
  assign pt_rd_prot  = rd_pte.prot;

  pgx_ctrl #(.IDX_W(PT_IDX_W)) u_ctrl (
    .clk, .rst_n,
    .req_valid, .req_ready, .req_vaddr, .req_kind,
    .flush(tlb_flush),
    .lk_vpn, .lk_hit, .lk_pfn, .lk_prot,
    .ins_en, .ins_vpn, .ins_pfn, .ins_prot,
    .walk_idx, .walk_pfn, .walk_vld, .walk_prot,
    .mark_en, .mark_idx, .mark_wr,
    .resp_valid, .resp_paddr,
    .resp_pgf(resp_page_fault), .resp_prf(resp_prot_fault)
  );

  pgx_tlb #(.DEPTH(TLB_DEPTH)) u_tlb (
    .clk, .rst_n,
    .lk_vpn, .lk_hit, .lk_pfn, .lk_prot,
    .flush(tlb_flush),
    .ins_en, .ins_vpn, .ins_pfn, .ins_prot,
    .vld_vec(tlb_vld)
  );

  pgx_ptab #(.IDX_W(PT_IDX_W)) u_ptab (
    .clk, .rst_n,
    .wr_en(pt_wr_en), .wr_idx(pt_wr_idx), .wr_pte,
    .mark_en, .mark_idx, .mark_wr,
    .a_idx(walk_idx), .a_pfn(walk_pfn), .a_vld(walk_vld), .a_prot(walk_prot),
    .b_idx(pt_rd_idx), .b_pte(rd_pte)
  );
endmodule

// File: rtl/pgx_chk.sv
module pgx_chk #(
  parameter int TLB_DEPTH = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 resp_valid,
  input logic [31:0]          resp_paddr,
  input logic                 resp_page_fault,
  input logic                 resp_prot_fault,
  input logic                 tlb_flush,
  input logic [TLB_DEPTH-1:0] tlb_vld
);
  p_fault_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !(resp_page_fault && resp_prot_fault));

  p_fault_zero_pa_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && (resp_page_fault || resp_prot_fault)) |-> (resp_paddr == 32'd0));

  p_hit_or_walk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (resp_valid || !req_ready));

  p_walk_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(req_ready)) |=> !req_ready);

  p_fill_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |=> (req_ready && resp_valid));

  p_resp_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(req_valid && req_ready) || $past(!req_ready)));

  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |=> (tlb_vld == '0));
endmodule

bind pgx_xlate pgx_chk #(.TLB_DEPTH(TLB_DEPTH)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .resp_valid(resp_valid),
  .resp_paddr(resp_paddr),
  .resp_page_fault(resp_page_fault),
  .resp_prot_fault(resp_prot_fault),
  .tlb_flush(tlb_flush),
  .tlb_vld(tlb_vld)
);

// File: tb/pgx_xlate_tb_top.sv
module pgx_xlate_tb_top;
  localparam int IW = 6;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [31:0]   req_vaddr;
  logic [1:0]    req_kind;
  logic          resp_valid;
  logic [31:0]   resp_paddr;
  logic          resp_page_fault;
  logic          resp_prot_fault;
  logic          tlb_flush;
  logic          pt_wr_en;
  logic [IW-1:0] pt_wr_idx;
  logic [22:0]   pt_wr_frame;
  logic          pt_wr_valid;
  logic          pt_wr_mod;
  logic          pt_wr_ref;
  logic [1:0]    pt_wr_prot;
  logic [IW-1:0] pt_rd_idx;
  logic [22:0]   pt_rd_frame;
  logic          pt_rd_valid;
  logic          pt_rd_mod;
  logic          pt_rd_ref;
  logic [1:0]    pt_rd_prot;

  int checks;
  int failures;

  pgx_xlate #(.TLB_DEPTH(8), .PT_IDX_W(IW)) dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_vaddr, .req_kind,
    .resp_valid, .resp_paddr, .resp_page_fault, .resp_prot_fault,
    .tlb_flush, .pt_wr_en, .pt_wr_idx, .pt_wr_frame, .pt_wr_valid,
    .pt_wr_mod, .pt_wr_ref, .pt_wr_prot, .pt_rd_idx, .pt_rd_frame,
    .pt_rd_valid, .pt_rd_mod, .pt_rd_ref, .pt_rd_prot
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish (actual hang, expected completion)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [31:0] va(input int page, input int off);
    return {23'(page), 9'(off)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pt_write(input int idx, input int frame, input bit v, input logic [1:0] prot);
    @(negedge clk);
    pt_wr_en    = 1'b1;
    pt_wr_idx   = IW'(idx);
    pt_wr_frame = 23'(frame);
    pt_wr_valid = v;
    pt_wr_mod   = 1'b0;
    pt_wr_ref   = 1'b0;
    pt_wr_prot  = prot;
    @(negedge clk);
    pt_wr_en    = 1'b0;
  endtask

  task automatic flush_pulse();
    @(negedge clk);
    tlb_flush = 1'b1;
    @(negedge clk);
    tlb_flush = 1'b0;
  endtask

  task automatic check_flags(input string tag, input int idx, input bit exp_ref, input bit exp_mod);
    pt_rd_idx = IW'(idx);
    #1;
    check({tag, " accessed flag"}, 32'(pt_rd_ref), 32'(exp_ref));
    check({tag, " dirty flag"}, 32'(pt_rd_mod), 32'(exp_mod));
  endtask

  task automatic wait_resp(output int lat);
    lat = 1;
    while (!resp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic expect_xl(input string tag, input logic [31:0] addr, input logic [1:0] kind,
                           input int exp_lat, input logic [31:0] exp_pa,
                           input bit exp_pgf, input bit exp_prf);
    int lat;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = addr;
    req_kind  = kind;
    @(negedge clk);
    req_valid = 1'b0;
    wait_resp(lat);
    check({tag, " latency"}, 32'(lat), 32'(exp_lat));
    check({tag, " paddr"}, resp_paddr, exp_pa);
    check({tag, " page fault"}, 32'(resp_page_fault), 32'(exp_pgf));
    check({tag, " prot fault"}, 32'(resp_prot_fault), 32'(exp_prf));
  endtask

  task automatic t_reset();
    check("R11 ready after reset", 32'(req_ready), 32'd1);
    check("R11 no response after reset", 32'(resp_valid), 32'd0);
    pt_rd_idx = IW'(5);
    #1;
    check("R11 table entry cleared", {pt_rd_frame, pt_rd_valid, pt_rd_mod, pt_rd_ref, pt_rd_prot, 4'b0}, 32'd0);
  endtask

  task automatic t_basic();
    pt_write(1, 2, 1'b1, 2'b10);
    expect_xl("R1 R6 R7 miss page1", 32'h0000_02D0, 2'b00, 3, 32'h0000_04D0, 1'b0, 1'b0);
    check_flags("R4 R5 after read miss", 1, 1'b1, 1'b0);
    expect_xl("R6 R7 hit page1", 32'h0000_02D4, 2'b00, 1, 32'h0000_04D4, 1'b0, 1'b0);
    expect_xl("R1 R5 write hit page1", 32'h0000_03FF, 2'b01, 1, {23'd2, 9'h1FF}, 1'b0, 1'b0);
    check_flags("R5 after write", 1, 1'b1, 1'b1);
  endtask

  task automatic t_page_fault();
    pt_write(3, 7, 1'b0, 2'b10);
    expect_xl("R2 invalid entry", va(3, 0), 2'b00, 3, 32'd0, 1'b1, 1'b0);
    check_flags("R2 R4 invalid untouched", 3, 1'b0, 1'b0);
    pt_write(0, 5, 1'b1, 2'b10);
    expect_xl("R2 out of range page", va(64, 4), 2'b01, 3, 32'd0, 1'b1, 1'b0);
    check_flags("R2 aliased entry untouched", 0, 1'b0, 1'b0);
    expect_xl("R2 R7 fault not cached", va(64, 4), 2'b00, 3, 32'd0, 1'b1, 1'b0);
  endtask

  task automatic t_protection();
    pt_write(4, 16, 1'b1, 2'b00);
    pt_write(5, 17, 1'b1, 2'b01);
    pt_write(6, 18, 1'b1, 2'b10);
    pt_write(7, 19, 1'b1, 2'b11);
    expect_xl("R3 perm 00 read", va(4, 0), 2'b00, 3, 32'd0, 1'b0, 1'b1);
    check_flags("R3 R4 denied untouched", 4, 1'b0, 1'b0);
    expect_xl("R3 perm 01 write", va(5, 0), 2'b01, 3, 32'd0, 1'b0, 1'b1);
    expect_xl("R3 R7 perm 01 read hit", va(5, 4), 2'b00, 1, {23'd17, 9'd4}, 1'b0, 1'b0);
    expect_xl("R3 perm 01 write hit", va(5, 8), 2'b01, 1, 32'd0, 1'b0, 1'b1);
    check_flags("R4 R5 perm 01 flags", 5, 1'b1, 1'b0);
    expect_xl("R3 perm 10 execute", va(6, 0), 2'b10, 3, 32'd0, 1'b0, 1'b1);
    expect_xl("R3 perm 11 execute", va(7, 8), 2'b10, 3, {23'd19, 9'd8}, 1'b0, 1'b0);
    expect_xl("R3 perm 11 write", va(7, 8), 2'b01, 1, 32'd0, 1'b0, 1'b1);
    expect_xl("R3 kind 11 never allowed", va(7, 8), 2'b11, 1, 32'd0, 1'b0, 1'b1);
  endtask

  task automatic t_stale_then_flush();
    pt_write(1, 9, 1'b1, 2'b10);
    expect_xl("R7 cached frame kept", va(1, 16), 2'b00, 1, {23'd2, 9'd16}, 1'b0, 1'b0);
    flush_pulse();
    expect_xl("R9 refetch after flush", va(1, 16), 2'b00, 3, {23'd9, 9'd16}, 1'b0, 1'b0);
  endtask

  task automatic t_write_priority();
    int lat;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid   = 1'b1;
    req_vaddr   = va(1, 1);
    req_kind    = 2'b01;
    pt_wr_en    = 1'b1;
    pt_wr_idx   = IW'(1);
    pt_wr_frame = 23'd9;
    pt_wr_valid = 1'b1;
    pt_wr_mod   = 1'b0;
    pt_wr_ref   = 1'b0;
    pt_wr_prot  = 2'b10;
    @(negedge clk);
    req_valid = 1'b0;
    pt_wr_en  = 1'b0;
    wait_resp(lat);
    check("R10 hit during table write latency", 32'(lat), 32'd1);
    check("R10 hit during table write paddr", resp_paddr, {23'd9, 9'd1});
    check_flags("R10 table write beats flag update", 1, 1'b0, 1'b0);
    expect_xl("R4 next hit", va(1, 2), 2'b00, 1, {23'd9, 9'd2}, 1'b0, 1'b0);
    check_flags("R4 flag set by hit", 1, 1'b1, 1'b0);
  endtask

  task automatic t_round_robin();
    flush_pulse();
    for (int i = 0; i < 9; i++) pt_write(10 + i, 64 + i, 1'b1, 2'b10);
    for (int i = 0; i < 9; i++)
      expect_xl("R8 fill slots", va(10 + i, i), 2'b00, 3, {23'(64 + i), 9'(i)}, 1'b0, 1'b0);
    expect_xl("R8 first page evicted", va(10, 3), 2'b00, 3, {23'd64, 9'd3}, 1'b0, 1'b0);
    expect_xl("R8 third page kept", va(12, 3), 2'b00, 1, {23'd66, 9'd3}, 1'b0, 1'b0);
    expect_xl("R8 second page evicted", va(11, 3), 2'b00, 3, {23'd65, 9'd3}, 1'b0, 1'b0);
    expect_xl("R8 fourth page kept", va(13, 3), 2'b00, 1, {23'd67, 9'd3}, 1'b0, 1'b0);
  endtask

  task automatic t_flush_mid_walk();
    int lat;
    flush_pulse();
    pt_write(20, 119, 1'b1, 2'b10);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va(20, 5);
    req_kind  = 2'b00;
    @(negedge clk);
    req_valid = 1'b0;
    tlb_flush = 1'b1;
    @(negedge clk);
    tlb_flush = 1'b0;
    lat = 2;
    while (!resp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check("R9 miss answers through flush latency", 32'(lat), 32'd3);
    check("R9 miss answers through flush paddr", resp_paddr, {23'd119, 9'd5});
    expect_xl("R9 killed install misses again", va(20, 6), 2'b00, 3, {23'd119, 9'd6}, 1'b0, 1'b0);
    expect_xl("R9 R7 installed afterwards", va(20, 7), 2'b00, 1, {23'd119, 9'd7}, 1'b0, 1'b0);
  endtask

  initial begin
    checks      = 0;
    failures    = 0;
    rst_n       = 1'b0;
    req_valid   = 1'b0;
    req_vaddr   = '0;
    req_kind    = '0;
    tlb_flush   = 1'b0;
    pt_wr_en    = 1'b0;
    pt_wr_idx   = '0;
    pt_wr_frame = '0;
    pt_wr_valid = 1'b0;
    pt_wr_mod   = 1'b0;
    pt_wr_ref   = 1'b0;
    pt_wr_prot  = '0;
    pt_rd_idx   = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_page_fault();
    t_protection();
    t_stale_then_flush();
    t_write_priority();
    t_round_robin();
    t_flush_mid_walk();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule